// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial-protocol peripheral core: idle-and-cleared (RESET), active (RUN) and halted-with-context (PAUSE). Software moves the core between states by writing a state code and learns the outcome by reading a status word. The status word holds the state field and a ready flag. A state counts as reached only once the ready flag is set and the field shows the wanted code.

Every accepted change drops the ready flag for a fixed settling window, and no new request is taken during that window. A software-reset strobe overrides everything and returns the core to RESET. A fatal tag error from the transfer engine, raised while running, parks the core in PAUSE.

Leaving PAUSE for RESET is guarded. Software must write the leave command twice in a row before the core acts on it. The transfer engine is told it may start only through a run output that is high solely in a settled RUN state. A matching pause output marks a settled PAUSE.

Top module: `run_state_ctrl`

## Requirements
- R1: After reset the status word reads 3'b100 (RESET, ready), and both run_out and pause_out are low.
- R2: The status word carries the state field in bits [1:0], coded RESET=0, RUN=1, PAUSE=3, and the ready flag in bit 2.
- R3: An accepted change shows the new code in the cycle after the request, with the ready flag low for exactly SETTLE (default 4) cycles. The flag then rises.
- R4: State writes and tag errors that arrive while the ready flag is low have no effect.
- R5: A write of a code above 3 is ignored. A write of code 2 outside PAUSE is ignored, and so is a write of code 0 while in PAUSE.
- R6: In PAUSE, a single write of code 2 leaves the core in PAUSE with ready high. A second write of code 2, with no other write accepted in between, moves the core to RESET. Any other write while ready clears the first one.
- R7: A sw_reset pulse forces RESET with the ready flag low in the next cycle, from any state, and also during a settling window, where it restarts the window.
- R8: tag_err in a settled RUN state moves the core to PAUSE and wins over a write in the same cycle. tag_err in any other state has no effect.
- R9: run_out is high only in a settled RUN state and pause_out only in a settled PAUSE state. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | State-write strobe, one cycle per write |
| wr_code | input | CODE_W (3) | Requested state code |
| sw_reset | input | 1 | Software reset strobe |
| tag_err | input | 1 | Fatal tag error from the transfer engine |
| state_rd | output | 3 | Status word: {ready, state[1:0]} |
| run_out | output | 1 | Transfer engine may start |
| pause_out | output | 1 | Core is held in PAUSE |

## Verification
The assertions take each strobe to be a single-cycle request that is sampled on the clock edge. They also assume SETTLE is at least 1, so the ready flag always drops after a change. The stimulus drives every input on the falling edge and holds it for one full cycle. Directed sequences cover writes during settling, tag errors racing writes, and sw_reset inside a window. A long run of random strobes and codes then exercises every pairing of inputs and states against the reference model.

// File: rtl/run_state_ctrl.sv
module run_state_ctrl #(
  parameter int SETTLE = 4,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              sw_reset,
  input  logic              tag_err,
  output logic [2:0]        state_rd,
  output logic              run_out,
  output logic              pause_out
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [1:0] ST_RESET = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_LEAVE = 2'd2;
  localparam logic [1:0] ST_PAUSE = 2'd3;

  logic [1:0]    st, st_nx;
  logic [CW-1:0] cnt;
  logic          arm, arm_nx, go;

  wire ready   = (cnt == '0);
  wire code_ok = (wr_code <= CODE_W'(3));

  always_comb begin
    st_nx  = st;
    arm_nx = arm;
    go     = 1'b0;
    if (sw_reset) begin
      st_nx  = ST_RESET;
      arm_nx = 1'b0;
      go     = 1'b1;
    end else if (ready) begin
      if (tag_err && st == ST_RUN) begin
        st_nx  = ST_PAUSE;
        arm_nx = 1'b0;
        go     = 1'b1;
      end else if (wr_en) begin
        arm_nx = 1'b0;
        if (code_ok) begin
          case (wr_code[1:0])
            ST_LEAVE: begin
              if (st == ST_PAUSE) begin
                if (arm) begin
                  st_nx = ST_RESET;
                  go    = 1'b1;
                end else begin
                  arm_nx = 1'b1;
                end
              end
            end
            ST_RESET: begin
              if (st != ST_PAUSE) begin
                st_nx = ST_RESET;
                go    = 1'b1;
              end
            end
            default: begin
              st_nx = wr_code[1:0];
              go    = 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RESET;
      cnt <= '0;
      arm <= 1'b0;
    end else begin
      st  <= st_nx;
      arm <= arm_nx;
      if (go)
        cnt <= CW'(SETTLE);
      else if (!ready)
        cnt <= cnt - 1'b1;
    end
  end

  assign state_rd  = {ready, st};
  assign run_out   = ready && (st == ST_RUN);
  assign pause_out = ready && (st == ST_PAUSE);

  AST_CHANGE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st) |-> !state_rd[2]); // R3

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_rd[2] && !sw_reset) |=> $stable(st)); // R4

  AST_HIGH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_rd[2] && wr_en && wr_code > CODE_W'(3) && !sw_reset && !tag_err) |=> ($stable(st) && state_rd[2])); // R5

  AST_LONE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_rd[2] && st == ST_PAUSE && wr_en && wr_code == CODE_W'(2) && !arm && !sw_reset && !tag_err)
      |=> (st == ST_PAUSE && state_rd[2])); // R6

  AST_SWRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (st == ST_RESET && !state_rd[2])); // R7

  AST_TAG_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_rd[2] && tag_err && st == ST_RUN && !sw_reset) |=> (st == ST_PAUSE)); // R8

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_out && pause_out)); // R9

endmodule

// File: tb/run_state_ctrl_tb.sv
module run_state_ctrl_tb;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_code = 3'd0;
  logic       sw_reset = 1'b0;
  logic       tag_err = 1'b0;
  logic [2:0] state_rd;
  logic       run_out, pause_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  int m_st = 0;
  int m_cnt = 0;
  int m_arm = 0;

  always #4 clk = ~clk;

  run_state_ctrl #(.SETTLE(SETTLE), .CODE_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .sw_reset(sw_reset), .tag_err(tag_err),
    .state_rd(state_rd), .run_out(run_out), .pause_out(pause_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_arm = 0;
    end else if (sw_reset) begin
      m_st = 0; m_cnt = SETTLE; m_arm = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end else if (tag_err && m_st == 1) begin
      m_st = 3; m_cnt = SETTLE; m_arm = 0;
    end else if (wr_en) begin
      if (wr_code == 2 && m_st == 3) begin
        if (m_arm == 1) begin
          m_st = 0; m_cnt = SETTLE; m_arm = 0;
        end else begin
          m_arm = 1;
        end
      end else begin
        m_arm = 0;
        if (wr_code == 1 || wr_code == 3) begin
          m_st = wr_code; m_cnt = SETTLE;
        end else if (wr_code == 0 && m_st != 3) begin
          m_st = 0; m_cnt = SETTLE;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 status word", state_rd, ((m_cnt == 0) ? 4 : 0) + m_st);
      chk("R9 run_out", run_out, (m_cnt == 0 && m_st == 1) ? 1 : 0);
      chk("R9 pause_out", pause_out, (m_cnt == 0 && m_st == 3) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int c);
    @(negedge clk); wr_en = 1'b1; wr_code = 3'(c);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle_to(input int st, input string req);
    idle(SETTLE);
    chk(req, state_rd, 4 + st);
  endtask

  initial begin
    idle(2);
    chk("R1 status after reset", state_rd, 4);
    chk("R1 run_out after reset", run_out, 0);
    chk("R1 pause_out after reset", pause_out, 0);
    rst_n = 1'b1;
    idle(1);

    wr(1);
    chk("R3 new code with ready low", state_rd, 1);
    idle(SETTLE - 1);
    chk("R3 still settling", state_rd, 1);
    idle(1);
    chk("R2 RUN settled", state_rd, 5);
    chk("R9 run_out in RUN", run_out, 1);

    wr(3);
    wr(0);
    idle(SETTLE - 1);
    chk("R4 write during settle ignored", state_rd, 7);

    wr(5);
    chk("R5 high code ignored", state_rd, 7);
    wr(1);
    idle(SETTLE);
    wr(2);
    chk("R5 leave code outside PAUSE ignored", state_rd, 5);

    @(negedge clk); tag_err = 1'b1; wr_en = 1'b1; wr_code = 3'd0;
    @(negedge clk); tag_err = 1'b0; wr_en = 1'b0;
    chk("R8 tag error wins and pauses", state_rd, 3);
    settle_to(3, "R8 PAUSE settled");
    chk("R9 pause_out in PAUSE", pause_out, 1);
    @(negedge clk); tag_err = 1'b1;
    @(negedge clk); tag_err = 1'b0;
    chk("R8 tag error in PAUSE ignored", state_rd, 7);

    wr(0);
    chk("R5 code 0 in PAUSE ignored", state_rd, 7);
    wr(2);
    chk("R6 single leave keeps PAUSE", state_rd, 7);
    wr(4);
    wr(2);
    chk("R6 interrupted pair keeps PAUSE", state_rd, 7);
    wr(2);
    chk("R6 second leave goes RESET", state_rd, 0);
    settle_to(0, "R6 RESET settled");

    wr(1);
    @(negedge clk); sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0;
    chk("R7 sw_reset during settle", state_rd, 0);
    settle_to(0, "R7 window restarted");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en    = ($urandom_range(0, 2) == 0);
      wr_code  = 3'($urandom_range(0, 7));
      tag_err  = ($urandom_range(0, 9) == 0);
      sw_reset = ($urandom_range(0, 39) == 0);
    end
    @(negedge clk);
    wr_en = 1'b0; tag_err = 1'b0; sw_reset = 1'b0;
    idle(SETTLE + 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule